// File: doc/BRIEF.md
# Refresh Sequencer with Abort and Reissue

This block runs CAS-before-RAS refresh cycles on a local DRAM bus. A refresh request input adds to a saturating count of owed refreshes. While any refresh is owed, the block asks for the bus. Once the bus is granted, it runs one refresh cycle.

A cycle lasts three bus states of four quarter-phases each (Q1 to Q4), so twelve clocks in all. During the cycle the block drives a 16-bit refresh row address in two places: on the upper half of a 32-bit address/data output, and on the row/column address pins. It also sequences the active-low RAS and CAS strobes.

The ready, fault and retry inputs are looked at only once per cycle, at the Q2 phase that follows the fall of RAS. If that single look shows an abort, the cycle is dropped. The count of owed refreshes and the address are both kept, so the same row is issued again on the next grant.

Top module: `refresh_seq`

## Requirements
- R1: CAS (`cas_n`) falls at Q3 of the first bus state, before RAS (`ras_n`) falls at Q1 of the second state, so CAS is already low whenever RAS falls.
- R2: The 16-bit refresh address starts at zero after reset and increases by one after each refresh cycle that completes.
- R3: While a cycle runs, `ad_out[31:16]` carries the refresh address and `ad_out[15:0]` is zero, with `ad_oe` high. Outside a cycle, `ad_out` is zero and `ad_oe` is low.
- R4: While a cycle runs, `rc_addr` carries the low `RCA_W` bits of the refresh address. Outside a cycle, it is zero.
- R5: `mem_ready`, `bus_fault` and `bus_retry` have no effect at any clock other than the one at Q2 of the second bus state, one quarter after RAS falls.
- R6: An abort leaves the owed-refresh count unchanged. An abort is `mem_ready` low, `bus_fault` high or `bus_retry` high at the sampling point. On an abort, the strobes and bus outputs go inactive on the next clock and no done pulse is given.
- R7: After an abort, the next cycle issues the same refresh address, and the address does not advance.
- R8: `prog_sel` and `size_16` have no effect on any output.
- R9: Each clock with `rfsh_req` high adds one owed refresh, up to a saturating maximum of 2^CNT_W-1. Each completed cycle removes one.
- R10: `bus_req` is high while a refresh is owed or a cycle runs. A cycle starts only on a clock where `bus_grant` is high, the block is idle and the count is nonzero, and it begins at Q1.
- R11: A completed cycle raises both strobes at Q4 of its third bus state. A one-clock `done` pulse follows on the next clock. `we_n` stays high throughout.
- R12: Reset clears the address and the owed count, and holds all strobes high with `bus_req`, `ad_oe` and `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one quarter-phase per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| rfsh_req | input | 1 | Adds one owed refresh per clock high |
| bus_grant | input | 1 | Bus granted to the sequencer |
| mem_ready | input | 1 | Ready; low at the sampling point preempts the cycle |
| bus_fault | input | 1 | Bus fault; high at the sampling point aborts |
| bus_retry | input | 1 | External retry; high at the sampling point aborts |
| prog_sel | input | 1 | Program/data select, ignored |
| size_16 | input | 1 | 16-bit size select, ignored |
| bus_req | output | 1 | Bus request |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low, held high |
| ad_out | output | 32 | Address/data bus value |
| ad_oe | output | 1 | Address/data bus drive enable |
| rc_addr | output | RCA_W | Row/column address pins |
| done | output | 1 | One-clock pulse after a completed refresh |

## Verification
The bench builds the block with CNT_W = 2, so the owed count saturates at three. That makes the drop of extra requests reachable with a short burst, and the count can be read back by counting done pulses until `bus_req` falls. RCA_W keeps its default of 13, so `rc_addr` shows a truncated copy of the 16-bit address. With the count this small, random request, grant and abort traffic visits both the full and the empty state often.

// File: rtl/refresh_seq.sv
module refresh_seq #(
  parameter int CNT_W = 4,
  parameter int RCA_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rfsh_req,
  input  logic             bus_grant,
  input  logic             mem_ready,
  input  logic             bus_fault,
  input  logic             bus_retry,
  input  logic             prog_sel,
  input  logic             size_16,
  output logic             bus_req,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [31:0]      ad_out,
  output logic             ad_oe,
  output logic [RCA_W-1:0] rc_addr,
  output logic             done
);
  localparam int ADDR_W = 16;
  localparam int PH_W = 4;
  localparam logic [PH_W-1:0] CAS_PH    = PH_W'(2);
  localparam logic [PH_W-1:0] RAS_PH    = PH_W'(4);
  localparam logic [PH_W-1:0] SAMPLE_PH = PH_W'(5);
  localparam logic [PH_W-1:0] LAST_PH   = PH_W'(11);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic              active;
  logic [PH_W-1:0]   ph;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr;
  logic              abort, finish, start, inc;
  logic              unused_inputs;

  assign unused_inputs = ^{prog_sel, size_16};

  assign abort  = active && ph == SAMPLE_PH && (!mem_ready || bus_fault || bus_retry);
  assign finish = active && ph == LAST_PH;
  assign start  = !active && bus_grant && cnt != '0;
  assign inc    = rfsh_req && (cnt != CNT_MAX || finish);

  assign bus_req = active || cnt != '0;
  assign cas_n   = !(active && ph >= CAS_PH && ph < LAST_PH);
  assign ras_n   = !(active && ph >= RAS_PH && ph < LAST_PH);
  assign we_n    = 1'b1;
  assign ad_oe   = active;
  assign ad_out  = active ? {addr, 16'h0000} : 32'h0;
  assign rc_addr = active ? addr[RCA_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      ph     <= '0;
      done   <= 1'b0;
      addr   <= '0;
    end else begin
      done <= finish;
      if (start) begin
        active <= 1'b1;
        ph     <= '0;
      end else if (abort || finish) begin
        active <= 1'b0;
        ph     <= '0;
      end else if (active) begin
        ph <= ph + 1'b1;
      end
      if (finish) addr <= addr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + CNT_W'(inc) - CNT_W'(finish);
  end

  assert_cbr_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> !cas_n);

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> addr == $past(addr) + 1'b1);

  assert_abort_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(active) && !active && !done) |-> $stable(addr));

  assert_abort_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ad_oe) && !done) |=> !done);

  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt) == CNT_MAX && !done) |-> cnt == CNT_MAX);

  assert_start_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ad_oe) |-> $past(bus_grant && bus_req));

  assert_done_after_strobes_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(!ras_n == 1'b0 && ad_oe) && ras_n && cas_n));
endmodule

// File: tb/refresh_seq_test.sv
module refresh_seq_test;
  localparam int CNT_W = 2;
  localparam int RCA_W = 13;
  localparam int MAXC = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rfsh_req = 0, bus_grant = 0, mem_ready = 1, bus_fault = 0, bus_retry = 0;
  logic prog_sel = 0, size_16 = 0;
  logic bus_req, ras_n, cas_n, we_n, ad_oe, done;
  logic [31:0] ad_out;
  logic [RCA_W-1:0] rc_addr;

  int checks = 0, fails = 0, ndone = 0;
  int m_act = 0, m_ph = 0, m_cnt = 0, m_addr = 0, m_done = 0;

  always #5 clk = ~clk;

  refresh_seq #(.CNT_W(CNT_W), .RCA_W(RCA_W)) uut (
    .clk, .rst_n, .rfsh_req, .bus_grant, .mem_ready, .bus_fault, .bus_retry,
    .prog_sel, .size_16, .bus_req, .ras_n, .cas_n, .we_n, .ad_out, .ad_oe,
    .rc_addr, .done);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_ph = 0; m_cnt = 0; m_addr = 0; m_done = 0;
    end else begin
      int fin;
      fin = 0;
      m_done = 0;
      if (m_act != 0) begin
        if (m_ph == 5 && (!mem_ready || bus_fault || bus_retry)) m_act = 0;
        else if (m_ph == 11) begin
          m_act = 0; m_done = 1; fin = 1; m_addr = (m_addr + 1) % 65536;
        end else m_ph++;
      end else if (bus_grant && m_cnt > 0) begin
        m_act = 1; m_ph = 0;
      end
      m_cnt -= fin;
      if (rfsh_req && m_cnt < MAXC) m_cnt++;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit a;
      a = (m_act != 0);
      chk(cas_n == !(a && m_ph >= 2 && m_ph <= 10), "R1 cas_n", cas_n, !(a && m_ph >= 2 && m_ph <= 10));
      chk(ras_n == !(a && m_ph >= 4 && m_ph <= 10), "R1 ras_n", ras_n, !(a && m_ph >= 4 && m_ph <= 10));
      chk(ad_out == (a ? {m_addr[15:0], 16'h0} : 32'h0) && ad_oe == a, "R3 ad_out", ad_out,
          a ? {m_addr[15:0], 16'h0} : 32'h0);
      chk(rc_addr == (a ? m_addr[RCA_W-1:0] : '0), "R4 rc_addr", rc_addr, a ? m_addr[RCA_W-1:0] : 0);
      chk(bus_req == (a || m_cnt != 0), "R10 bus_req", bus_req, a || m_cnt != 0);
      chk(done == m_done[0] && we_n, "R11 done/we_n", {done, we_n}, {m_done[0], 1'b1});
      if (done) ndone++;
    end
  end

  task automatic cyc(); @(negedge clk); endtask

  task automatic pulse_req();
    rfsh_req = 1; cyc(); rfsh_req = 0;
  endtask

  task automatic wait_done(input int n);
    int start = ndone;
    for (int i = 0; i < 200 && ndone < start + n; i++) cyc();
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    int d0;
    logic [31:0] seen;
    repeat (3) cyc();
    chk(ras_n && cas_n && we_n && !bus_req && !ad_oe && !done, "R12 reset",
        {ras_n, cas_n, we_n, bus_req, ad_oe, done}, 6'b111000);
    rst_n = 1;
    cyc();

    bus_grant = 1;
    pulse_req();
    wait_done(1);
    cyc();
    pulse_req();
    while (!ad_oe) cyc();
    chk(ad_out == 32'h0001_0000, "R2 address advanced", ad_out, 32'h0001_0000);
    chk(rc_addr == 13'd1, "R4 rc_addr follows", rc_addr, 1);
    wait_done(1);
    cyc();

    for (int k = 0; k < 3; k++) begin
      pulse_req();
      while (!(m_act != 0 && m_ph == 5)) cyc();
      seen = ad_out;
      if (k == 0) bus_fault = 1; else if (k == 1) bus_retry = 1; else mem_ready = 0;
      cyc();
      bus_fault = 0; bus_retry = 0; mem_ready = 1;
      chk(!ad_oe && !done, "R6 abort drops cycle", ad_oe, 0);
      cyc();
      chk(!done, "R6 no done after abort", done, 0);
      while (!ad_oe) cyc();
      chk(ad_out == seen, "R7 same address reissued", ad_out, seen);
      d0 = ndone;
      wait_done(1);
      cyc(); cyc();
      chk(ndone == d0 + 1 && !bus_req, "R6 count kept one owed", ndone - d0, 1);
    end
    pulse_req();
    while (!ad_oe) cyc();
    chk(ad_out[31:16] == 16'd5, "R7 no advance on abort", ad_out[31:16], 5);
    wait_done(1);
    cyc();

    bus_grant = 0;
    repeat (5) pulse_req();
    repeat (4) cyc();
    chk(!ad_oe && bus_req, "R10 no start without grant", {ad_oe, bus_req}, 2'b01);
    d0 = ndone;
    bus_grant = 1;
    for (int i = 0; i < 200 && bus_req; i++) cyc();
    cyc();
    chk(ndone - d0 == MAXC, "R9 saturating count", ndone - d0, MAXC);

    d0 = ndone;
    pulse_req();
    for (int i = 0; i < 40 && ndone == d0; i++) begin
      if (m_act != 0 && m_ph == 5) begin
        mem_ready = 1; bus_fault = 0; bus_retry = 0;
      end else begin
        mem_ready = 0; bus_fault = 1; bus_retry = 1;
      end
      prog_sel = $urandom_range(0, 1);
      size_16 = $urandom_range(0, 1);
      cyc();
    end
    mem_ready = 1; bus_fault = 0; bus_retry = 0;
    chk(ndone == d0 + 1, "R5 inputs outside sample ignored", ndone - d0, 1);
    chk(ndone == d0 + 1, "R8 prog_sel/size_16 ignored", ndone - d0, 1);

    for (int i = 0; i < 3000; i++) begin
      rfsh_req  = ($urandom_range(0, 7) == 0);
      bus_grant = ($urandom_range(0, 3) != 0);
      mem_ready = ($urandom_range(0, 9) != 0);
      bus_fault = ($urandom_range(0, 19) == 0);
      bus_retry = ($urandom_range(0, 19) == 0);
      prog_sel  = $urandom_range(0, 1);
      size_16   = $urandom_range(0, 1);
      cyc();
    end
    rfsh_req = 0;
    cyc();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule